// File: doc/BRIEF.md
# Windowed Command and Interrupt-Status Controller

This block sits behind a host register port. It turns 16-bit command words into actions and keeps the adapter's interrupt status word. A command word carries a 5-bit opcode in its top bits and an 11-bit argument below it. The block uses that argument as a register-window number, as an acknowledge mask, or as an interrupt-enable mask. The window number selects which bank of registers the rest of the chip shows to the host. The block only tracks this number and reports it in the status word; the banks themselves live elsewhere.

The datapath reports events as level inputs. The block latches the rising edge of each one into a status bit. Each bit stays set until the host acknowledges it. The interrupt request output is high while any latched event is also enabled in the mask. A global-reset command clears the whole state and then holds a command-in-progress flag for a configurable number of cycles. The block drops any command written while that flag is high.

Top module: `cmd_irq_ctrl`

## Requirements
- R1: A command word holds the opcode in bits 15..11 and the argument in bits 10..0. An opcode other than 0, 1, 12, 13 or 14 changes nothing in the status word or on the interrupt output.
- R2: Opcode 1 loads the window from argument bits 2..0, and argument bits 10..3 are ignored. The status word shows the window in bits 15..13, and the window changes only by opcode 1, opcode 0 or reset.
- R3: Status bits 8..11 always read 0. Bit 12 reads 1 exactly while a command is in progress.
- R4: A 0-to-1 transition on event input k (k = 1..7) sets status bit k one clock edge later. An event input that stays high does not set its bit again.
- R5: Opcode 13 clears each status bit i (0..7) whose argument bit i is 1. An event rising edge in the same cycle wins, so that bit ends up set.
- R6: Opcode 14 loads the interrupt mask from argument bits 7..1. The irq output equals the OR of status bits 7..1 ANDed with the mask. Status bit 0 is set on the clock edge after any cycle in which irq is high.
- R7: Opcode 12 sets status bit 6 (interrupt requested).
- R8: Opcode 0 clears the status bits, the mask and the window. It then holds bit 12 high for RST_CYCLES cycles.
- R9: Commands written while bit 12 is high are ignored. The first command after it falls takes effect.
- R10: While rst is high at a clock edge, the status word becomes 0 and irq becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Command write strobe, one command per cycle it is high |
| host_wdata | input | 16 | Command word: opcode 15..11, argument 10..0 |
| evt_in | input | 7 | Event levels from the datapath; bit k feeds status bit k (k = 1..7) |
| host_status | output | 16 | Status word: window, in-progress flag, event bits |
| irq | output | 1 | Interrupt request |

## Verification
Every command effect and every latched event is one register stage deep. The bench therefore drives inputs on the falling edge and compares the status word on the next falling edge. The irq output follows the latched bits and the mask with no further delay, so it is checked on that same sample. Status bit 0 needs one more edge, because it records that irq was high, and its expected value is modelled one row later than the event that raised irq. After a global reset the bench samples the in-progress flag on each of the following cycles and writes a command on each of them. The flag must cover exactly RST_CYCLES samples, and none of those writes may reach the window.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int OPC_W    = 5;
    localparam int ARG_W    = 11;
    localparam int WORD_W   = OPC_W + ARG_W;
    localparam int WIN_W    = 3;
    localparam int EVT_BITS = 8;
    localparam int REQ_BIT  = 6;
    localparam int RSV_W    = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_GLOBAL_RESET = 5'd0,
        OP_WINDOW_SEL   = 5'd1,
        OP_REQ_INT      = 5'd12,
        OP_ACK          = 5'd13,
        OP_SET_MASK     = 5'd14
    } op_e;

    typedef struct packed {
        logic             greset;
        logic             winsel;
        logic             reqint;
        logic             ack;
        logic             setmask;
        logic [ARG_W-1:0] arg;
    } cmd_s;

    function automatic cmd_s decode_cmd(input logic [WORD_W-1:0] w, input logic accept);
        cmd_s c;
        c     = '0;
        c.arg = w[ARG_W-1:0];
        if (accept) begin
            case (op_e'(w[WORD_W-1:ARG_W]))
                OP_GLOBAL_RESET: c.greset  = 1'b1;
                OP_WINDOW_SEL:   c.winsel  = 1'b1;
                OP_REQ_INT:      c.reqint  = 1'b1;
                OP_ACK:          c.ack     = 1'b1;
                OP_SET_MASK:     c.setmask = 1'b1;
                default:         c         = c;
            endcase
        end
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(
        input logic [WIN_W-1:0]    win,
        input logic                busy,
        input logic [EVT_BITS-1:0] bits
    );
        return {win, busy, {RSV_W{1'b0}}, bits};
    endfunction

endpackage

// File: rtl/cic_decode.sv
module cic_decode
    import cic_pkg::*;
(
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              busy,
    output cmd_s              cmd
);
    logic accept;

    assign accept = host_wr && !busy;

    always_comb begin
        cmd = decode_cmd(host_wdata, accept);
    end

endmodule

// File: rtl/cic_busy.sv
module cic_busy #(
    parameter int RST_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start) begin
            remain <= CNT_W'(RST_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R8

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (remain < $past(remain))); // R9

endmodule

// File: rtl/cic_status.sv
module cic_status
    import cic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic [EVT_BITS-1:1] evt,
    input  logic                ack_en,
    input  logic [EVT_BITS-1:0] ack_bits,
    input  logic                req_en,
    input  logic                mask_en,
    input  logic [EVT_BITS-1:1] mask_val,
    output logic [EVT_BITS-1:0] bits,
    output logic                irq
);
    logic [EVT_BITS-1:1] evt_q;
    logic [EVT_BITS-1:1] rise;
    logic [EVT_BITS-1:1] mask_q;
    logic [EVT_BITS-1:1] ev_bits;
    logic                latch_q;

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt;
    end

    assign rise = evt & ~evt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)   mask_q <= '0;
        else if (mask_en) mask_q <= mask_val;
    end

    for (genvar i = 1; i < EVT_BITS; i++) begin : g_evbit
        logic set_i;
        assign set_i = rise[i] || (req_en && (i == REQ_BIT));

        always_ff @(posedge clk) begin
            if (rst || clr)                  ev_bits[i] <= 1'b0;
            else if (set_i)                  ev_bits[i] <= 1'b1;
            else if (ack_en && ack_bits[i])  ev_bits[i] <= 1'b0;
        end

        AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
            (rise[i] && !clr) |=> bits[i]); // R4

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (ack_en && ack_bits[i] && !rise[i] && !clr) |=> !bits[i]); // R5
    end

    assign irq = |(ev_bits & mask_q);

    always_ff @(posedge clk) begin
        if (rst || clr)                  latch_q <= 1'b0;
        else if (irq)                    latch_q <= 1'b1;
        else if (ack_en && ack_bits[0])  latch_q <= 1'b0;
    end

    assign bits = {ev_bits, latch_q};

    AST_LATCH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> bits[0]); // R6

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bits == '0 && !irq)); // R8

endmodule

// File: rtl/cmd_irq_ctrl.sv
module cmd_irq_ctrl
    import cic_pkg::*;
#(
    parameter int RST_CYCLES = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [WORD_W-1:0]   host_wdata,
    input  logic [EVT_BITS-1:1] evt_in,
    output logic [WORD_W-1:0]   host_status,
    output logic                irq
);
    cmd_s                cmd;
    logic                busy;
    logic [WIN_W-1:0]    window_q;
    logic [EVT_BITS-1:0] bits;
    logic [ARG_W-1:EVT_BITS] unused_arg_hi;

    cic_decode u_decode (
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .busy       (busy),
        .cmd        (cmd)
    );

    cic_busy #(.RST_CYCLES(RST_CYCLES)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (cmd.greset),
        .busy  (busy)
    );

    cic_status u_status (
        .clk      (clk),
        .rst      (rst),
        .clr      (cmd.greset),
        .evt      (evt_in),
        .ack_en   (cmd.ack),
        .ack_bits (cmd.arg[EVT_BITS-1:0]),
        .req_en   (cmd.reqint),
        .mask_en  (cmd.setmask),
        .mask_val (cmd.arg[EVT_BITS-1:1]),
        .bits     (bits),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd.greset) window_q <= '0;
        else if (cmd.winsel)   window_q <= cmd.arg[WIN_W-1:0];
    end

    assign unused_arg_hi = cmd.arg[ARG_W-1:EVT_BITS];

    assign host_status = pack_status(window_q, busy, bits);

    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cmd.winsel || cmd.greset) |=> $stable(window_q)); // R2

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (busy && host_wr) |=> $stable(window_q)); // R9

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        host_status[11:8] == 4'b0000); // R3

endmodule

// File: tb/cmd_irq_ctrl_test.sv
module cmd_irq_ctrl_test;

    localparam int RSTC  = 4;
    localparam int NROWS = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [7:1]  evt_in = '0;
    logic [15:0] host_status;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    cmd_irq_ctrl #(.RST_CYCLES(RSTC)) uut (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .evt_in      (evt_in),
        .host_status (host_status),
        .irq         (irq)
    );

    // row: {wdata[16], wr[1], evt[8] (bit 0 unused), expected status[16], expected irq[1]}
    localparam logic [41:0] VEC [NROWS] = '{
        {16'h0803, 1'b1, 8'h00, 16'h6000, 1'b0},
        {16'h70FE, 1'b1, 8'h00, 16'h6000, 1'b0},
        {16'h0000, 1'b0, 8'h04, 16'h6004, 1'b1},
        {16'h0000, 1'b0, 8'h00, 16'h6005, 1'b1},
        {16'h6804, 1'b1, 8'h00, 16'h6001, 1'b0},
        {16'h6801, 1'b1, 8'h00, 16'h6000, 1'b0},
        {16'h6000, 1'b1, 8'h00, 16'h6040, 1'b1},
        {16'h7000, 1'b1, 8'h00, 16'h6041, 1'b0},
        {16'h68C1, 1'b1, 8'h80, 16'h6080, 1'b0},
        {16'h0000, 1'b0, 8'h80, 16'h6080, 1'b0},
        {16'h6880, 1'b1, 8'h80, 16'h6000, 1'b0},
        {16'h3FFF, 1'b1, 8'h00, 16'h6000, 1'b0},
        {16'h0FFD, 1'b1, 8'h00, 16'hA000, 1'b0},
        {16'h7002, 1'b1, 8'h02, 16'hA002, 1'b1},
        {16'h0000, 1'b0, 8'h00, 16'hA003, 1'b1}
    };

    localparam string RTAG [NROWS] = '{
        "R2 R3", "R6", "R4 R6", "R6", "R5 R6", "R5 R6", "R7", "R6",
        "R5", "R4", "R4 R5", "R1", "R2", "R6", "R6"
    };

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: status actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: irq actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [15:0] w, input logic [7:1] e);
        host_wr    = wr;
        host_wdata = w;
        evt_in     = e;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check16("R10", host_status, 16'h0000);
        check1("R10", irq, 1'b0);

        for (int r = 0; r < NROWS; r++) begin
            step(VEC[r][25], VEC[r][41:26], VEC[r][24:18]);
            check16(RTAG[r], host_status, VEC[r][16:1]);
            check1(RTAG[r], irq, VEC[r][0]);
        end

        // R8: global reset clears everything and raises busy
        step(1'b1, 16'h0000, 7'h00);
        check16("R8", host_status, 16'h1000);
        check1("R8", irq, 1'b0);

        // R9: writes during busy are dropped; busy lasts RSTC samples (R3)
        for (int k = 1; k <= RSTC; k++) begin
            step(1'b1, 16'h0802, 7'h00);
            check16("R9", host_status, (k < RSTC) ? 16'h1000 : 16'h0000);
        end
        step(1'b0, 16'h0000, 7'h00);
        check16("R3", host_status, 16'h0000);

        // R9: first command after busy falls is accepted
        step(1'b1, 16'h0806, 7'h00);
        check16("R9", host_status, 16'hC000);

        // R8: mask was cleared, so a new event does not raise irq
        step(1'b0, 16'h0000, 7'h01);
        check16("R8", host_status, 16'hC002);
        check1("R8", irq, 1'b0);
        step(1'b0, 16'h0000, 7'h00);
        check1("R8", irq, 1'b0);

        // R10: reset in mid run
        step(1'b1, 16'h7002, 7'h00);
        check1("R6", irq, 1'b1);
        rst = 1'b1;
        step(1'b0, 16'h0000, 7'h00);
        rst = 1'b0;
        check16("R10", host_status, 16'h0000);
        check1("R10", irq, 1'b0);

        finish_run();
    end

endmodule